// File: doc/BRIEF.md
# Operand Effective Address Generator

This block finds where an instruction operand lives for a 16-bit processor with sixteen 16-bit registers and seven ways of naming an operand. The decoder supplies a 3-bit mode code, the register number and that register's current contents, the program counter, the extension word that trails the opcode, and a flag that marks a byte-sized operation. From these the block works out the operand's memory address and flags that tell the surrounding pipeline three things: whether memory is touched at all, whether the operand is the extension word itself, and whether an extension word is consumed.

Address results and flags are purely combinational, so they settle within the same cycle as the inputs. For the post-increment mode, the block also issues a single-cycle registered write-back request one clock after an access strobe. The request carries the register number and the advanced pointer. The register file, memory, instruction decode and ALU all sit outside the block.

Top module: `oper_loc_gen`

## Requirements
- R1: Mode codes are 0 register, 1 immediate, 2 absolute, 3 indexed, 4 symbolic, 5 indirect, 6 post-increment; code 7 raises `err_o` and forces `ea_o` to 0, clears `addr_valid_o`, `is_imm_o` and `uses_ext_o`, and never produces a write-back.
- R2: In register mode (code 0) the operand is the register itself: `addr_valid_o`, `is_imm_o` and `uses_ext_o` are 0 and `ea_o` is 0.
- R3: In immediate mode (code 1) `is_imm_o` and `uses_ext_o` are 1, `addr_valid_o` is 0 and `ea_o` is 0.
- R4: In absolute mode (code 2) `ea_o` equals `ext_i`, with `addr_valid_o` and `uses_ext_o` both 1.
- R5: In indexed mode (code 3) `ea_o` equals `reg_val_i + ext_i` modulo 2^16, with `addr_valid_o` and `uses_ext_o` both 1.
- R6: In symbolic mode (code 4) `ea_o` equals `pc_i + ext_i` modulo 2^16, with `addr_valid_o` and `uses_ext_o` both 1.
- R7: In indirect mode (code 5) `ea_o` equals `reg_val_i`, `addr_valid_o` is 1 and `uses_ext_o` is 0.
- R8: In post-increment mode (code 6) `ea_o` equals the unmodified `reg_val_i`, `addr_valid_o` is 1 and `uses_ext_o` is 0.
- R9: One clock after a cycle with `step_i` high and code 6, `wb_en_o` is high for that one cycle, `wb_idx_o` holds the sampled `reg_sel_i`, and `wb_val_o` holds the sampled `reg_val_i` plus 1 when `byte_i` was 1 or plus 2 when it was 0, modulo 2^16.
- R10: One clock after any cycle with `step_i` low or a code other than 6, `wb_en_o` is 0.
- R11: While `rst_n` is low and at the first cycle after reset, `wb_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | The operand access happens in this cycle |
| mode_i | input | 3 | Mode code 0 to 6; 7 is invalid |
| reg_sel_i | input | 4 | Register number named by the instruction |
| reg_val_i | input | 16 | Current contents of that register |
| pc_i | input | 16 | Program counter used by symbolic mode |
| ext_i | input | 16 | Extension word that follows the opcode |
| byte_i | input | 1 | 1 for a byte operation, 0 for a word operation |
| ea_o | output | 16 | Effective operand address |
| addr_valid_o | output | 1 | The operand is in memory at `ea_o` |
| is_imm_o | output | 1 | The operand is the extension word itself |
| uses_ext_o | output | 1 | An extension word is consumed |
| err_o | output | 1 | Invalid mode code |
| wb_en_o | output | 1 | Registered pointer write-back strobe |
| wb_idx_o | output | 4 | Register to write back |
| wb_val_o | output | 16 | Advanced pointer value |

## Verification
The bench uses the default parameters: a 16-bit address, 16 registers, and the shared-adder variant. These defaults make the carry out of bit 15 observable. The bench drives directed cases near 0xFFFF for the indexed and symbolic sums and for byte and word post-increment, and checks that each result wraps to a small address. All sixteen register numbers appear in the write-back index. Because the bench keeps a register model updated from the write-back port, back-to-back post-increment accesses to the same register walk a pointer across the wrap point.

// File: rtl/oper_loc_pkg.sv
package oper_loc_pkg;

   typedef enum logic [2:0] {
      AM_REG = 3'd0,
      AM_IMM = 3'd1,
      AM_ABS = 3'd2,
      AM_IDX = 3'd3,
      AM_SYM = 3'd4,
      AM_IND = 3'd5,
      AM_INC = 3'd6,
      AM_BAD = 3'd7
   } amode_t;

   typedef enum logic [1:0] {
      BS_ZERO = 2'd0,
      BS_REG  = 2'd1,
      BS_PC   = 2'd2
   } base_sel_t;

   typedef struct packed {
      logic      addr_valid;
      logic      uses_ext;
      logic      is_imm;
      logic      err;
      logic      post_inc;
      logic      add_ext;
      base_sel_t base;
   } dec_t;

endpackage

// File: rtl/oper_loc_decode.sv
module oper_loc_decode
   import oper_loc_pkg::*;
(
   input  logic [2:0] mode_i,
   output dec_t       dec_o
);

   amode_t mode;
   assign mode = amode_t'(mode_i);

   always_comb begin
      dec_o = '{addr_valid: 1'b0, uses_ext: 1'b0, is_imm: 1'b0, err: 1'b0,
                post_inc: 1'b0, add_ext: 1'b0, base: BS_ZERO};
      case (mode)
         AM_REG: ;
         AM_IMM: begin
            dec_o.is_imm   = 1'b1;
            dec_o.uses_ext = 1'b1;
         end
         AM_ABS: begin
            dec_o.addr_valid = 1'b1;
            dec_o.uses_ext   = 1'b1;
            dec_o.add_ext    = 1'b1;
         end
         AM_IDX: begin
            dec_o.addr_valid = 1'b1;
            dec_o.uses_ext   = 1'b1;
            dec_o.add_ext    = 1'b1;
            dec_o.base       = BS_REG;
         end
         AM_SYM: begin
            dec_o.addr_valid = 1'b1;
            dec_o.uses_ext   = 1'b1;
            dec_o.add_ext    = 1'b1;
            dec_o.base       = BS_PC;
         end
         AM_IND: begin
            dec_o.addr_valid = 1'b1;
            dec_o.base       = BS_REG;
         end
         AM_INC: begin
            dec_o.addr_valid = 1'b1;
            dec_o.post_inc   = 1'b1;
            dec_o.base       = BS_REG;
         end
         default: dec_o.err = 1'b1;
      endcase
   end

endmodule

// File: rtl/oper_loc_addr.sv
module oper_loc_addr
   import oper_loc_pkg::*;
#(
   parameter int AW         = 16,
   parameter bit SHARED_ADD = 1'b1
)(
   input  base_sel_t         base_i,
   input  logic              add_ext_i,
   input  logic [AW-1:0]     reg_val_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [AW-1:0]     ext_i,
   output logic [AW-1:0]     ea_o
);

   logic [AW-1:0] offset;
   assign offset = add_ext_i ? ext_i : '0;

   generate
      if (SHARED_ADD) begin : g_shared
         logic [AW-1:0] base_val;
         always_comb begin
            case (base_i)
               BS_REG:  base_val = reg_val_i;
               BS_PC:   base_val = pc_i;
               default: base_val = '0;
            endcase
         end
         assign ea_o = base_val + offset;
      end else begin : g_split
         logic [AW-1:0] sum_reg;
         logic [AW-1:0] sum_pc;
         assign sum_reg = reg_val_i + offset;
         assign sum_pc  = pc_i + offset;
         always_comb begin
            case (base_i)
               BS_REG:  ea_o = sum_reg;
               BS_PC:   ea_o = sum_pc;
               default: ea_o = offset;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/oper_loc_wb.sv
module oper_loc_wb #(
   parameter int AW = 16,
   parameter int RW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire_i,
   input  logic          byte_i,
   input  logic [RW-1:0] sel_i,
   input  logic [AW-1:0] ptr_i,
   output logic          wb_en_o,
   output logic [RW-1:0] wb_idx_o,
   output logic [AW-1:0] wb_val_o
);

   localparam logic [AW-1:0] STEP_BYTE = AW'(1);
   localparam logic [AW-1:0] STEP_WORD = AW'(2);

   logic [AW-1:0] next_ptr;
   assign next_ptr = ptr_i + (byte_i ? STEP_BYTE : STEP_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en_o  <= 1'b0;
         wb_idx_o <= '0;
         wb_val_o <= '0;
      end else begin
         wb_en_o <= fire_i;
         if (fire_i) begin
            wb_idx_o <= sel_i;
            wb_val_o <= next_ptr;
         end
      end
   end

endmodule

// File: rtl/oper_loc_gen.sv
module oper_loc_gen
   import oper_loc_pkg::*;
#(
   parameter int AW         = 16,
   parameter int NREG       = 16,
   parameter bit SHARED_ADD = 1'b1,
   localparam int RW        = $clog2(NREG)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_i,
   input  logic [2:0]    mode_i,
   input  logic [RW-1:0] reg_sel_i,
   input  logic [AW-1:0] reg_val_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] ext_i,
   input  logic          byte_i,
   output logic [AW-1:0] ea_o,
   output logic          addr_valid_o,
   output logic          is_imm_o,
   output logic          uses_ext_o,
   output logic          err_o,
   output logic          wb_en_o,
   output logic [RW-1:0] wb_idx_o,
   output logic [AW-1:0] wb_val_o
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("oper_loc_gen: AW must be at least 2");
      end
      if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_nreg
         $error("oper_loc_gen: NREG must be a power of two, at least 2");
      end
   endgenerate

   dec_t dec;

   oper_loc_decode u_dec (
      .mode_i (mode_i),
      .dec_o  (dec)
   );

   oper_loc_addr #(.AW(AW), .SHARED_ADD(SHARED_ADD)) u_addr (
      .base_i    (dec.base),
      .add_ext_i (dec.add_ext),
      .reg_val_i (reg_val_i),
      .pc_i      (pc_i),
      .ext_i     (ext_i),
      .ea_o      (ea_o)
   );

   oper_loc_wb #(.AW(AW), .RW(RW)) u_wb (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (step_i && dec.post_inc),
      .byte_i   (byte_i),
      .sel_i    (reg_sel_i),
      .ptr_i    (reg_val_i),
      .wb_en_o  (wb_en_o),
      .wb_idx_o (wb_idx_o),
      .wb_val_o (wb_val_o)
   );

   assign addr_valid_o = dec.addr_valid;
   assign is_imm_o     = dec.is_imm;
   assign uses_ext_o   = dec.uses_ext;
   assign err_o        = dec.err;

endmodule

// File: rtl/oper_loc_chk.sv
module oper_loc_chk #(
   parameter int AW = 16,
   parameter int RW = 4
)(
   input logic          clk,
   input logic          rst_n,
   input logic          step_i,
   input logic [2:0]    mode_i,
   input logic [RW-1:0] reg_sel_i,
   input logic [AW-1:0] reg_val_i,
   input logic [AW-1:0] pc_i,
   input logic [AW-1:0] ext_i,
   input logic          byte_i,
   input logic [AW-1:0] ea_o,
   input logic          addr_valid_o,
   input logic          is_imm_o,
   input logic          uses_ext_o,
   input logic          err_o,
   input logic          wb_en_o,
   input logic [RW-1:0] wb_idx_o,
   input logic [AW-1:0] wb_val_o
);

   p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!addr_valid_o && !is_imm_o && !uses_ext_o && ea_o == '0));

   p_imm_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_imm_o |-> (uses_ext_o && !addr_valid_o && !err_o));

   p_abs_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd2) |-> (ea_o == ext_i));

   p_sym_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd4) |-> (ea_o == AW'(pc_i + ext_i)));

   p_inc_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd6) |-> (ea_o == reg_val_i && !uses_ext_o));

   p_wb_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && mode_i == 3'd6) |=>
         (wb_en_o && wb_idx_o == $past(reg_sel_i) &&
          wb_val_o == AW'($past(reg_val_i) + ($past(byte_i) ? AW'(1) : AW'(2)))));

   p_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_i && mode_i == 3'd6) |=> !wb_en_o);

endmodule

bind oper_loc_gen oper_loc_chk #(.AW(AW), .RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .step_i(step_i), .mode_i(mode_i),
   .reg_sel_i(reg_sel_i), .reg_val_i(reg_val_i), .pc_i(pc_i), .ext_i(ext_i),
   .byte_i(byte_i), .ea_o(ea_o), .addr_valid_o(addr_valid_o),
   .is_imm_o(is_imm_o), .uses_ext_o(uses_ext_o), .err_o(err_o),
   .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o)
);

// File: tb/oper_loc_gen_test.sv
module oper_loc_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0;
   logic [2:0]  mode_i = 3'd0;
   logic [3:0]  reg_sel_i = 4'd0;
   logic [15:0] reg_val_i = 16'd0;
   logic [15:0] pc_i = 16'd0;
   logic [15:0] ext_i = 16'd0;
   logic        byte_i = 1'b0;
   logic [15:0] ea_o;
   logic        addr_valid_o, is_imm_o, uses_ext_o, err_o, wb_en_o;
   logic [3:0]  wb_idx_o;
   logic [15:0] wb_val_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] regs [16];
   logic        exp_en = 1'b0;
   logic [3:0]  exp_idx = 4'd0;
   logic [15:0] exp_val = 16'd0;

   always #10 clk = ~clk;

   oper_loc_gen uut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .mode_i(mode_i),
      .reg_sel_i(reg_sel_i), .reg_val_i(reg_val_i), .pc_i(pc_i), .ext_i(ext_i),
      .byte_i(byte_i), .ea_o(ea_o), .addr_valid_o(addr_valid_o),
      .is_imm_o(is_imm_o), .uses_ext_o(uses_ext_o), .err_o(err_o),
      .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_ea(input logic [2:0] m, input logic [15:0] r,
                                          input logic [15:0] pc, input logic [15:0] x);
      case (m)
         3'd2: return x;
         3'd3: return r + x;
         3'd4: return pc + x;
         3'd5, 3'd6: return r;
         default: return 16'd0;
      endcase
   endfunction

   function automatic string tag(input logic [2:0] m);
      case (m)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         3'd6: return "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic do_op(input logic [2:0] m, input logic [3:0] sel, input logic [15:0] pc,
                        input logic [15:0] x, input logic b, input logic st);
      string t;
      @(negedge clk);
      if (exp_en) begin
         check("R9 wb_en", {31'd0, wb_en_o}, 32'd1);
         check("R9 wb_idx", {28'd0, wb_idx_o}, {28'd0, exp_idx});
         check("R9 wb_val", {16'd0, wb_val_o}, {16'd0, exp_val});
      end else begin
         check("R10 wb_en low", {31'd0, wb_en_o}, 32'd0);
      end
      if (wb_en_o) regs[wb_idx_o] = wb_val_o;
      mode_i = m; reg_sel_i = sel; reg_val_i = regs[sel]; pc_i = pc; ext_i = x;
      byte_i = b; step_i = st;
      #2;
      t = tag(m);
      check({t, " ea"}, {16'd0, ea_o}, {16'd0, exp_ea(m, regs[sel], pc, x)});
      check({t, " addr_valid"}, {31'd0, addr_valid_o}, {31'd0, (m >= 3'd2 && m <= 3'd6)});
      check({t, " is_imm"}, {31'd0, is_imm_o}, {31'd0, (m == 3'd1)});
      check({t, " uses_ext"}, {31'd0, uses_ext_o}, {31'd0, (m >= 3'd1 && m <= 3'd4)});
      check({t, " err"}, {31'd0, err_o}, {31'd0, (m == 3'd7)});
      exp_en  = st && (m == 3'd6);
      exp_idx = sel;
      exp_val = regs[sel] + (b ? 16'd1 : 16'd2);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) regs[i] = 16'($urandom());
      repeat (3) @(negedge clk);
      check("R11 wb_en in reset", {31'd0, wb_en_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 wb_en after reset", {31'd0, wb_en_o}, 32'd0);

      // directed corners
      regs[4] = 16'hFFFF;
      do_op(3'd6, 4'd4, 16'h0000, 16'h1234, 1'b1, 1'b1); // R9 byte wrap -> 0000
      do_op(3'd6, 4'd4, 16'h0000, 16'h0000, 1'b0, 1'b1); // pointer now 0000, word
      regs[5] = 16'hFFFF;
      do_op(3'd6, 4'd5, 16'h0000, 16'h0000, 1'b0, 1'b1); // R9 word wrap -> 0001
      do_op(3'd6, 4'd5, 16'h0000, 16'h0000, 1'b0, 1'b0); // R10 no step
      regs[6] = 16'hFFF0;
      do_op(3'd3, 4'd6, 16'h0000, 16'h0020, 1'b0, 1'b1); // R5 wrap -> 0010
      do_op(3'd4, 4'd6, 16'hFFFE, 16'h0004, 1'b0, 1'b1); // R6 wrap -> 0002
      do_op(3'd7, 4'd6, 16'h1111, 16'h2222, 1'b0, 1'b1); // R1 invalid, no wb
      do_op(3'd0, 4'd6, 16'h1111, 16'h2222, 1'b1, 1'b1); // R2
      do_op(3'd1, 4'd6, 16'h1111, 16'h2222, 1'b1, 1'b1); // R3
      do_op(3'd2, 4'd6, 16'h1111, 16'hABCD, 1'b1, 1'b1); // R4
      do_op(3'd5, 4'd6, 16'h1111, 16'h2222, 1'b1, 1'b1); // R7
      for (int k = 0; k < 16; k++)
         do_op(3'd6, 4'(k), 16'h0, 16'h0, k[0], 1'b1);    // R9 every index

      for (int n = 0; n < 800; n++) begin
         logic [2:0] m;
         m = ($urandom_range(0, 3) == 0) ? 3'd6 : 3'($urandom_range(0, 7));
         do_op(m, 4'($urandom_range(0, 15)), 16'($urandom()), 16'($urandom()),
               1'($urandom()), ($urandom_range(0, 4) != 0));
      end
      do_op(3'd0, 4'd0, 16'h0, 16'h0, 1'b0, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule